// File: doc/BRIEF.md
# Wait-For-Event Sleep Controller

This block sits beside a processor core and decides when the core may stop, what low-power depth it asks for, and when it must resume. It holds a single event flag. A wait-for-event request either uses up a flag that is already set and returns at once, or puts the core to sleep until a wake source fires. A wait-for-interrupt request always sleeps and resumes only on a taken exception.

Events come from several places: a send-event request from this core, an event input from other cores, a taken exception, a debug entry request when debug is enabled, and optionally any pending-interrupt bit that newly rises. A send-event request is also echoed to other clusters as a one-cycle pulse. When the core goes to sleep, the block records the low-power depth selected by three control bits and reports it until the core wakes.

Top module: `wfe_sleep_ctrl`

## Requirements
- R1: A wait-for-event request while awake, with the event flag set or with an event arriving in the same cycle, raises `wake` in that cycle, leaves `asleep` low and clears the flag, so the following wait-for-event request sleeps.
- R2: A wait-for-event request while awake, with the flag clear and no event in that cycle, sets `asleep` from the next cycle, and `asleep` stays high until a wake source fires.
- R3: While asleep after a wait-for-event request, `sev_req`, `event_in`, `exc_take`, or `dbg_req` with `dbg_en`=1 raises `wake` in that same cycle; `dbg_req` with `dbg_en`=0 has no effect.
- R4: With `pend_event_en`=1, a 0-to-1 change of any bit of `pend_vec` is an event; a bit held at 1 gives no further event; with `pend_event_en`=0 pending bits give no event.
- R5: An event that occurs while awake or during a wait-for-interrupt sleep sets the flag, so the next wait-for-event request returns at once; this includes an exception taken between two wait-for-event requests.
- R6: `sev_req` sets the event flag, and `event_out` is high in the cycle after each cycle in which `sev_req` is high.
- R7: A wait-for-interrupt request sleeps whatever the flag holds, and that sleep ends only on `exc_take`; `sev_req`, `event_in` and `dbg_req` do not wake it.
- R8: `lp_mode` reads 0 while awake; while asleep it holds the depth captured in the cycle of the sleep request: 0 plain sleep when `deep_en`=0; with `deep_en`=1, 3 standby when `power_down`=1, else 2 when `lp_reg`=1 and 1 when `lp_reg`=0. Changes of the control bits during sleep do not alter it.
- R9: After reset `asleep`, `wake`, `event_out` and `lp_mode` are 0 and the event flag is clear, so the first wait-for-event request sleeps.
- R10: `wake` from a sleep lasts one cycle, and `asleep` is low from the cycle after it.
- R11: When wait-for-event and wait-for-interrupt requests arrive together, the wait-for-event request is the one served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wfe_req | input | 1 | Wait-for-event request pulse |
| wfi_req | input | 1 | Wait-for-interrupt request pulse |
| sev_req | input | 1 | Send-event request pulse from this core |
| event_in | input | 1 | Event pulse from other cores or clusters |
| pend_vec | input | NPEND | Pending-interrupt bits, one per source |
| exc_take | input | 1 | Unmasked exception taken |
| dbg_req | input | 1 | Debug entry request |
| dbg_en | input | 1 | Debug enabled |
| pend_event_en | input | 1 | Newly pending interrupts count as events |
| deep_en | input | 1 | Deep sleep selected |
| power_down | input | 1 | Deep sleep goes to standby |
| lp_reg | input | 1 | Stop uses the low-power regulator |
| asleep | output | 1 | Core is sleeping |
| lp_mode | output | 2 | Low-power depth (0 sleep, 1 stop main regulator, 2 stop low-power regulator, 3 standby) |
| wake | output | 1 | One-cycle wake or immediate-return pulse |
| event_out | output | 1 | Event pulse to other clusters |

## Verification
The bench aims at the flag's life across requests: an event landing while awake, an exception slipped between two back-to-back wait-for-event requests, and an event in the very cycle of the request; a design that dropped any of these would sleep with work pending and hang. It holds a pending bit high across a sleep to catch a level-triggered design that wakes over and over, and it fires the non-interrupt sources during a wait-for-interrupt sleep to catch one that wakes on them. It also changes the depth controls mid-sleep to catch a mode output that tracks the live bits instead of the captured ones.

// File: rtl/wfe_sleep_ctrl.sv
module wfe_sleep_ctrl #(
  parameter int NPEND = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wfe_req,
  input  logic             wfi_req,
  input  logic             sev_req,
  input  logic             event_in,
  input  logic [NPEND-1:0] pend_vec,
  input  logic             exc_take,
  input  logic             dbg_req,
  input  logic             dbg_en,
  input  logic             pend_event_en,
  input  logic             deep_en,
  input  logic             power_down,
  input  logic             lp_reg,
  output logic             asleep,
  output logic [1:0]       lp_mode,
  output logic             wake,
  output logic             event_out
);

  typedef enum logic [1:0] {S_RUN, S_WFE, S_WFI} state_t;

  state_t           state, state_n;
  logic             ev_latch, ev_latch_n;
  logic [NPEND-1:0] pend_q;
  logic [1:0]       mode_q, mode_sel;
  logic             new_pend, ev_src, go_sleep;

  assign new_pend = |(pend_vec & ~pend_q);
  assign ev_src   = sev_req | event_in | exc_take | (dbg_req & dbg_en)
                  | (pend_event_en & new_pend);

  assign mode_sel = !deep_en   ? 2'd0 :
                    power_down ? 2'd3 :
                    lp_reg     ? 2'd2 : 2'd1;

  always_comb begin
    state_n    = state;
    ev_latch_n = ev_latch;
    wake       = 1'b0;
    go_sleep   = 1'b0;
    unique case (state)
      S_RUN: begin
        if (wfe_req) begin
          ev_latch_n = 1'b0;
          if (ev_latch || ev_src) begin
            wake = 1'b1;
          end else begin
            state_n  = S_WFE;
            go_sleep = 1'b1;
          end
        end else begin
          if (ev_src) ev_latch_n = 1'b1;
          if (wfi_req) begin
            state_n  = S_WFI;
            go_sleep = 1'b1;
          end
        end
      end
      S_WFE: begin
        ev_latch_n = 1'b0;
        if (ev_src) begin
          wake    = 1'b1;
          state_n = S_RUN;
        end
      end
      S_WFI: begin
        if (ev_src) ev_latch_n = 1'b1;
        if (exc_take) begin
          wake    = 1'b1;
          state_n = S_RUN;
        end
      end
      default: state_n = S_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_RUN;
      ev_latch  <= 1'b0;
      pend_q    <= '0;
      mode_q    <= 2'd0;
      event_out <= 1'b0;
    end else begin
      state     <= state_n;
      ev_latch  <= ev_latch_n;
      pend_q    <= pend_vec;
      event_out <= sev_req;
      if (go_sleep) mode_q <= mode_sel;
    end
  end

  assign asleep  = (state != S_RUN);
  assign lp_mode = asleep ? mode_q : 2'd0;

  assert_hit_returns_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && wfe_req && (ev_latch || ev_src)) |=> !asleep);

  assert_miss_sleeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && wfe_req && !ev_latch && !ev_src) |=> asleep);

  assert_sev_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && sev_req && !wfe_req) |=> ev_latch);

  assert_wfi_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WFI && !exc_take) |=> asleep);

  assert_mode_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && $past(asleep)) |-> $stable(lp_mode));

  assert_wake_ends_sleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && wake) |=> !asleep);

endmodule

// File: tb/wfe_sleep_ctrl_test.sv
module wfe_sleep_ctrl_test;
  localparam int NP = 4;

  localparam logic [5:0] IDLE = 6'b000000, WFE = 6'b100000, WFI = 6'b010000,
                         SEV  = 6'b001000, EVI = 6'b000100, EXC = 6'b000010,
                         DBG  = 6'b000001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wfe_req = 0, wfi_req = 0, sev_req = 0, event_in = 0, exc_take = 0, dbg_req = 0;
  logic [NP-1:0] pend_vec = '0;
  logic dbg_en = 0, pend_event_en = 0, deep_en = 0, power_down = 0, lp_reg = 0;
  logic c_dbg = 0, c_pen = 0, c_deep = 0, c_pd = 0, c_lp = 0;
  logic asleep, wake, event_out;
  logic [1:0] lp_mode;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [4:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  wfe_sleep_ctrl #(.NPEND(NP)) uut (
    .clk(clk), .rst_n(rst_n), .wfe_req(wfe_req), .wfi_req(wfi_req),
    .sev_req(sev_req), .event_in(event_in), .pend_vec(pend_vec),
    .exc_take(exc_take), .dbg_req(dbg_req), .dbg_en(dbg_en),
    .pend_event_en(pend_event_en), .deep_en(deep_en), .power_down(power_down),
    .lp_reg(lp_reg), .asleep(asleep), .lp_mode(lp_mode), .wake(wake),
    .event_out(event_out)
  );

  // exp = {wake, asleep, event_out, lp_mode}
  task automatic step(input logic [5:0] s, input logic [NP-1:0] p,
                      input logic [4:0] exp, input string tag);
    @(posedge clk); #1;
    {wfe_req, wfi_req, sev_req, event_in, exc_take, dbg_req} = s;
    pend_vec = p;
    dbg_en = c_dbg; pend_event_en = c_pen;
    deep_en = c_deep; power_down = c_pd; lp_reg = c_lp;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [4:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      tests++;
      if ({wake, asleep, event_out, lp_mode} !== e) begin
        fails++;
        $display("FAIL %s: got wake=%b asleep=%b evo=%b mode=%0d, expected wake=%b asleep=%b evo=%b mode=%0d",
                 t, wake, asleep, event_out, lp_mode, e[4], e[3], e[2], e[1:0]);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step(IDLE, 0, 5'b00000, "R9 reset state");
    step(WFE,  0, 5'b00000, "R9 flag clear after reset");
    step(IDLE, 0, 5'b01000, "R2 sleeping");
    step(IDLE, 0, 5'b01000, "R2 stays asleep");
    step(SEV,  0, 5'b11000, "R3 sev wakes");
    step(IDLE, 0, 5'b00100, "R10 asleep drops, R6 evo");
    step(IDLE, 0, 5'b00000, "R6 evo one cycle");
    step(WFE,  0, 5'b00000, "R2 sleep again");
    step(EVI,  0, 5'b11000, "R3 event_in wakes");
    step(IDLE, 0, 5'b00000, "R10");
    step(WFE,  0, 5'b00000, "R2");
    step(DBG,  0, 5'b01000, "R3 debug ignored when disabled");
    step(IDLE, 0, 5'b01000, "R3 still asleep");
    c_dbg = 1;
    step(DBG,  0, 5'b11000, "R3 debug wakes");
    step(IDLE, 0, 5'b00000, "R10");
    step(WFE,  0, 5'b00000, "R2");
    step(IDLE, 0, 5'b01000, "R2");
    step(EXC,  0, 5'b11000, "R3 exception wakes");
    step(IDLE, 0, 5'b00000, "R10");
    step(EVI,  0, 5'b00000, "R5 event while awake");
    step(IDLE, 0, 5'b00000, "R5");
    step(WFE,  0, 5'b10000, "R1 immediate return");
    step(IDLE, 0, 5'b00000, "R1 no sleep");
    step(WFE,  0, 5'b00000, "R1 flag cleared");
    step(IDLE, 0, 5'b01000, "R1 second request sleeps");
    step(SEV,  0, 5'b11000, "R3");
    step(IDLE, 0, 5'b00100, "R6");
    step(WFE | EXC, 0, 5'b10000, "R1 same-cycle event");
    step(IDLE, 0, 5'b00000, "R1");
    step(SEV,  0, 5'b00000, "R6 sev sets flag");
    step(WFE,  0, 5'b10100, "R6 flag used");
    step(EXC,  0, 5'b00000, "R5 exception between requests");
    step(WFE,  0, 5'b10000, "R5 second request returns");
    step(IDLE, 0, 5'b00000, "R5");
    step(WFE,  0, 5'b00000, "R2");
    step(IDLE, 4'b0001, 5'b01000, "R4 pending ignored when disabled");
    c_pen = 1;
    step(IDLE, 4'b0000, 5'b01000, "R4");
    step(IDLE, 4'b0001, 5'b11000, "R4 rising pending wakes");
    step(IDLE, 4'b0001, 5'b00000, "R10");
    step(WFE,  4'b0001, 5'b00000, "R4 held bit no event");
    step(IDLE, 4'b0001, 5'b01000, "R4 held bit no wake");
    step(IDLE, 4'b0011, 5'b11000, "R4 other bit rises");
    step(IDLE, 4'b0000, 5'b00000, "R10");
    step(IDLE, 4'b0010, 5'b00000, "R4 pending while awake");
    step(WFE,  4'b0000, 5'b10000, "R4 latched pending returns");
    step(IDLE, 0, 5'b00000, "R1");
    step(SEV,  0, 5'b00000, "R6");
    step(WFI,  0, 5'b00100, "R7 wfi despite flag");
    step(IDLE, 0, 5'b01000, "R7 asleep");
    step(EVI,  0, 5'b01000, "R7 event_in no wake");
    step(DBG,  0, 5'b01000, "R7 debug no wake");
    step(SEV,  0, 5'b01000, "R7 sev no wake");
    step(EXC,  0, 5'b11100, "R7 exception wakes");
    step(IDLE, 0, 5'b00000, "R10");
    step(WFE,  0, 5'b10000, "R5 flag kept through wfi");
    step(IDLE, 0, 5'b00000, "R5");
    step(WFE | WFI, 0, 5'b00000, "R11 both requests");
    step(SEV,  0, 5'b11000, "R11 served as wfe");
    step(IDLE, 0, 5'b00100, "R11");
    c_deep = 1; c_pd = 1;
    step(WFI,  0, 5'b00000, "R8 awake mode 0");
    c_pd = 0; c_lp = 1;
    step(IDLE, 0, 5'b01011, "R8 standby");
    step(IDLE, 0, 5'b01011, "R8 captured mode held");
    step(EXC,  0, 5'b11011, "R8");
    step(WFI,  0, 5'b00000, "R8");
    c_lp = 0;
    step(IDLE, 0, 5'b01010, "R8 stop low-power regulator");
    step(EXC,  0, 5'b11010, "R8");
    step(WFI,  0, 5'b00000, "R8");
    c_deep = 0; c_pd = 1;
    step(IDLE, 0, 5'b01001, "R8 stop main regulator");
    step(EXC,  0, 5'b11001, "R8");
    step(WFI,  0, 5'b00000, "R8");
    step(IDLE, 0, 5'b01000, "R8 plain sleep");
    step(EXC,  0, 5'b11000, "R8");
    step(IDLE, 0, 5'b00000, "R8 mode 0 when awake");
    step(SEV,  0, 5'b00000, "R6");
    step(IDLE, 0, 5'b00100, "R6 pulse");
    step(IDLE, 0, 5'b00000, "R6 pulse ends");
    step(WFE,  0, 5'b10000, "R1");
    step(WFE,  0, 5'b00000, "R1 cleared");
    step(IDLE, 0, 5'b01000, "R1");
    step(EXC,  0, 5'b11000, "R3");
    step(IDLE, 0, 5'b00000, "R10");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout, expected end of sequence");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule